// File: doc/BRIEF.md
# Clock Rate Probe Sequencer

This block measures the frequency of a selected clock by driving an external frequency counter through its control and status lines. When a request arrives, it records the current state of the divide-by-four reference branch enable and switches the branch on. It then runs two counter windows back to back: a short one of 0x1000 reference ticks, followed by a full one of 0x10000 ticks. Afterwards it writes the saved branch state back.

A counter attached to a stopped clock does not clear. The block therefore treats two identical raw counts as a stopped clock and reports zero. Otherwise it scales the full count and corrects it for gating offset: the count is multiplied by ten, fifteen is added, and the result is multiplied by the 4.8 MHz reference rate. This value is divided by ten times the full window plus thirty-five, using a restoring divider that produces one quotient bit per cycle. The quotient, times a multiplier of one, is presented as a 32-bit rate in Hz together with a one-cycle valid pulse.

States: `ST_IDLE` moves to `ST_REF_ON` on an accepted request. `ST_REF_ON` moves to `ST_ARM`. `ST_ARM` moves to `ST_WAIT_LOW`. `ST_WAIT_LOW` moves to `ST_GO` once ready reads 0. `ST_GO` moves to `ST_WAIT_HIGH`. `ST_WAIT_HIGH` moves on once ready reads 1: to `ST_ARM` after the short window, or to `ST_RESTORE` after the full window. `ST_RESTORE` moves to `ST_CALC`. `ST_CALC` moves to `ST_DONE` when the counts match, or to `ST_DIVIDE` when they differ. `ST_DIVIDE` moves to `ST_DONE` when the divider finishes. `ST_DONE` returns to `ST_IDLE`.

Top module: `clk_rate_probe`

## Requirements
- R1: While reset is held and immediately after it, busy, rate_valid, cnt_wr and ref_en_wr are 0 and rate is 0.
- R2: An accepted request first captures ref_en_q. In the first busy cycle it then issues a branch write (ref_en_wr=1) with ref_en_d=1.
- R3: Each counter window begins with a control write (cnt_wr=1) with cnt_start=0. A write with cnt_start=1 follows only after cnt_ready has been sampled as 0.
- R4: After the start write, the block waits for cnt_ready to read 1 and only then captures the 25-bit cnt_value. Values present while ready is 0 are never used.
- R5: Exactly four control writes occur per sequence, in this order of (cnt_ticks, cnt_start): (0x1000,0), (0x1000,1), (0x10000,0), (0x10000,1).
- R6: After the full window, a second branch write restores ref_en_d to the value captured in R2.
- R7: When the full and short raw counts are equal, the reported rate is 0.
- R8: Otherwise the rate is floor(((full*10)+15)*4800000 / 655395) times 1, computed exactly over a 64-bit dividend. This includes the maximum count 0x1FFFFFF and the case of a full count below the short count.
- R9: rate_valid is high for exactly one cycle, in which busy is still 1. rate keeps its value after the pulse until the next result.
- R10: A request that arrives while busy is ignored: the sequence gives one result and four control writes. busy stays 1 from acceptance through the valid cycle and then returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Measurement request, sampled in idle |
| busy | output | 1 | Sequence in progress |
| rate | output | 32 | Measured rate in Hz |
| rate_valid | output | 1 | One-cycle result strobe |
| cnt_ticks | output | 20 | Reference tick count for the counter window |
| cnt_start | output | 1 | Start bit of the control write |
| cnt_wr | output | 1 | Control write strobe |
| cnt_ready | input | 1 | Counter ready/done status |
| cnt_value | input | 25 | Counter raw result |
| ref_en_q | input | 1 | Current divide-by-four branch enable |
| ref_en_wr | output | 1 | Branch enable write strobe |
| ref_en_d | output | 1 | Branch enable write data |

## Verification
On every cycle, the assertions check several local rules: a start write is always preceded by a sampled-low ready, rate_valid is a single-cycle strobe inside busy, and a sequence cannot drop out of busy before its result. They also check that no write leaves the block while it is idle, that the branch is switched on as the first busy action, and that matching counts always yield a zero rate. Only the directed scenarios can show the exact order of the four writes with their tick values, the restoration of both branch states, and the arithmetic of the rate for chosen counts. The same holds for slow-ready counters and for requests ignored during a run.

// File: rtl/clk_rate_probe_pkg.sv
package clk_rate_probe_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_REF_ON,
        ST_ARM,
        ST_WAIT_LOW,
        ST_GO,
        ST_WAIT_HIGH,
        ST_RESTORE,
        ST_CALC,
        ST_DIVIDE,
        ST_DONE
    } crp_state_e;

endpackage

// File: rtl/crp_rate_prep.sv
module crp_rate_prep #(
    parameter int unsigned CNT_W  = 25,
    parameter int unsigned DVD_W  = 64,
    parameter int unsigned REF_HZ = 4800000
) (
    input  logic [CNT_W-1:0] short_cnt,
    input  logic [CNT_W-1:0] full_cnt,
    output logic             is_off,
    output logic [DVD_W-1:0] dividend
);
    localparam logic [DVD_W-1:0] REF_V = DVD_W'(REF_HZ);

    // gating-offset corrected, scaled count
    logic [DVD_W-1:0] corrected;

    assign is_off    = (short_cnt == full_cnt);
    assign corrected = DVD_W'(full_cnt) * DVD_W'(10) + DVD_W'(15);
    assign dividend  = corrected * REF_V;
endmodule

// File: rtl/crp_restoring_div.sv
module crp_restoring_div #(
    parameter int unsigned DVD_W = 64,
    parameter int unsigned DSR_W = 32,
    parameter int unsigned Q_W   = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DVD_W-1:0] dividend,
    input  logic [DSR_W-1:0] divisor,
    output logic             done,
    output logic [Q_W-1:0]   quotient
);
    localparam int unsigned CW = $clog2(DVD_W + 1);

    logic [DVD_W-1:0] shq_q;
    logic [DSR_W-1:0] rem_q;
    logic [CW-1:0]    left_q;
    logic             run_q;
    logic [DSR_W:0]   trial;
    logic [DSR_W:0]   diff;

    assign trial    = {rem_q, shq_q[DVD_W-1]};
    assign diff     = trial - {1'b0, divisor};
    assign quotient = shq_q[Q_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shq_q  <= '0;
            rem_q  <= '0;
            left_q <= '0;
            run_q  <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                shq_q  <= dividend;
                rem_q  <= '0;
                left_q <= CW'(DVD_W);
                run_q  <= 1'b1;
            end else if (run_q) begin
                if (diff[DSR_W]) begin
                    rem_q <= trial[DSR_W-1:0];
                    shq_q <= {shq_q[DVD_W-2:0], 1'b0};
                end else begin
                    rem_q <= diff[DSR_W-1:0];
                    shq_q <= {shq_q[DVD_W-2:0], 1'b1};
                end
                left_q <= left_q - 1'b1;
                if (left_q == CW'(1)) begin
                    run_q <= 1'b0;
                    done  <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/clk_rate_probe.sv
module clk_rate_probe
    import clk_rate_probe_pkg::*;
#(
    parameter int unsigned TICK_W      = 20,
    parameter int unsigned CNT_W       = 25,
    parameter int unsigned RATE_W      = 32,
    parameter int unsigned SHORT_TICKS = 32'h1000,
    parameter int unsigned FULL_TICKS  = 32'h10000,
    parameter int unsigned REF_HZ      = 4800000,
    parameter int unsigned MULT        = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    output logic              busy,
    output logic [RATE_W-1:0] rate,
    output logic              rate_valid,
    output logic [TICK_W-1:0] cnt_ticks,
    output logic              cnt_start,
    output logic              cnt_wr,
    input  logic              cnt_ready,
    input  logic [CNT_W-1:0]  cnt_value,
    input  logic              ref_en_q,
    output logic              ref_en_wr,
    output logic              ref_en_d
);
    localparam int unsigned       DVD_W   = 64;
    localparam int unsigned       DSR_W   = 32;
    localparam logic [DSR_W-1:0]  DIVISOR = DSR_W'(FULL_TICKS) * DSR_W'(10) + DSR_W'(35);
    localparam logic [RATE_W-1:0] MULT_V  = RATE_W'(MULT);

    crp_state_e        state_q, state_d;
    logic              full_run_q;
    logic              saved_ref_q;
    logic [CNT_W-1:0]  short_q, full_q;
    logic [RATE_W-1:0] rate_q;
    logic              div_start, div_done, is_off;
    logic [DVD_W-1:0]  dividend;
    logic [RATE_W-1:0] div_quot;

    crp_rate_prep #(.CNT_W(CNT_W), .DVD_W(DVD_W), .REF_HZ(REF_HZ)) prep_i (
        .short_cnt (short_q),
        .full_cnt  (full_q),
        .is_off    (is_off),
        .dividend  (dividend)
    );

    crp_restoring_div #(.DVD_W(DVD_W), .DSR_W(DSR_W), .Q_W(RATE_W)) div_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .dividend (dividend),
        .divisor  (DIVISOR),
        .done     (div_done),
        .quotient (div_quot)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (req) state_d = ST_REF_ON;
            ST_REF_ON:    state_d = ST_ARM;
            ST_ARM:       state_d = ST_WAIT_LOW;
            ST_WAIT_LOW:  if (!cnt_ready) state_d = ST_GO;
            ST_GO:        state_d = ST_WAIT_HIGH;
            ST_WAIT_HIGH: if (cnt_ready) state_d = full_run_q ? ST_RESTORE : ST_ARM;
            ST_RESTORE:   state_d = ST_CALC;
            ST_CALC:      state_d = is_off ? ST_DONE : ST_DIVIDE;
            ST_DIVIDE:    if (div_done) state_d = ST_DONE;
            ST_DONE:      state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy       = 1'b1;
        cnt_wr     = 1'b0;
        cnt_start  = 1'b0;
        ref_en_wr  = 1'b0;
        ref_en_d   = 1'b0;
        rate_valid = 1'b0;
        div_start  = 1'b0;
        unique case (state_q)
            ST_IDLE:    busy = 1'b0;
            ST_REF_ON:  begin ref_en_wr = 1'b1; ref_en_d = 1'b1; end
            ST_ARM:     cnt_wr = 1'b1;
            ST_GO:      begin cnt_wr = 1'b1; cnt_start = 1'b1; end
            ST_RESTORE: begin ref_en_wr = 1'b1; ref_en_d = saved_ref_q; end
            ST_CALC:    div_start = !is_off;
            ST_DONE:    rate_valid = 1'b1;
            default:    ;
        endcase
    end

    assign cnt_ticks = full_run_q ? TICK_W'(FULL_TICKS) : TICK_W'(SHORT_TICKS);
    assign rate      = rate_q;

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_run_q  <= 1'b0;
            saved_ref_q <= 1'b0;
            short_q     <= '0;
            full_q      <= '0;
            rate_q      <= '0;
        end else begin
            if (state_q == ST_IDLE && req) saved_ref_q <= ref_en_q;
            if (state_q == ST_REF_ON) full_run_q <= 1'b0;
            if (state_q == ST_WAIT_HIGH && cnt_ready) begin
                if (full_run_q) full_q <= cnt_value;
                else begin
                    short_q    <= cnt_value;
                    full_run_q <= 1'b1;
                end
            end
            if (state_q == ST_CALC && is_off) rate_q <= '0;
            if (state_q == ST_DIVIDE && div_done) rate_q <= div_quot * MULT_V;
        end
    end
endmodule

// File: rtl/crp_checker.sv
module crp_checker #(
    parameter int unsigned CNT_W  = 25,
    parameter int unsigned RATE_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              rate_valid,
    input logic [RATE_W-1:0] rate,
    input logic              cnt_wr,
    input logic              cnt_start,
    input logic              cnt_ready,
    input logic              ref_en_wr,
    input logic              ref_en_d,
    input logic [CNT_W-1:0]  short_q,
    input logic [CNT_W-1:0]  full_q
);
    p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!cnt_wr && !ref_en_wr && !rate_valid));

    p_ref_on_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (ref_en_wr && ref_en_d));

    p_start_after_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr && cnt_start) |-> $past(!cnt_ready));

    p_off_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_valid && short_q == full_q) |-> (rate == '0));

    p_valid_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rate_valid |=> !rate_valid);

    p_valid_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rate_valid |-> busy);

    p_rate_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> $stable(rate));

    p_busy_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rate_valid) |=> busy);
endmodule

bind clk_rate_probe crp_checker #(.CNT_W(CNT_W), .RATE_W(RATE_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .rate_valid (rate_valid),
    .rate       (rate),
    .cnt_wr     (cnt_wr),
    .cnt_start  (cnt_start),
    .cnt_ready  (cnt_ready),
    .ref_en_wr  (ref_en_wr),
    .ref_en_d   (ref_en_d),
    .short_q    (short_q),
    .full_q     (full_q)
);

// File: tb/clk_rate_probe_tb_top.sv
module clk_rate_probe_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        busy;
    logic [31:0] rate;
    logic        rate_valid;
    logic [19:0] cnt_ticks;
    logic        cnt_start;
    logic        cnt_wr;
    logic        cnt_ready = 1'b1;
    logic [24:0] cnt_value = '0;
    logic        ref_en_q = 1'b0;
    logic        ref_en_wr;
    logic        ref_en_d;

    int total = 0;
    int bad = 0;

    // counter / branch model state
    int unsigned short_v, full_v;
    int low_dly = 2;
    int low_tmr = 0, high_tmr = 0;
    int run_idx = 0, wr_n = 0, ref_n = 0, viol = 0, valid_n = 0;
    logic [19:0] wr_ticks [0:7];
    logic        wr_st    [0:7];
    logic        ref_log  [0:3];

    always #5 clk = ~clk;

    clk_rate_probe dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .busy(busy), .rate(rate),
        .rate_valid(rate_valid), .cnt_ticks(cnt_ticks), .cnt_start(cnt_start),
        .cnt_wr(cnt_wr), .cnt_ready(cnt_ready), .cnt_value(cnt_value),
        .ref_en_q(ref_en_q), .ref_en_wr(ref_en_wr), .ref_en_d(ref_en_d)
    );

    function automatic longint unsigned exp_rate(int unsigned s, int unsigned f);
        longint unsigned n;
        if (s == f) return 0;
        n = ((longint'(f) * 10) + 15) * 4800000;
        return (n / 655395) & 64'hFFFF_FFFF;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // frequency counter and branch register model
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (rate_valid) valid_n++;
                if (ref_en_wr) begin
                    if (ref_n < 4) ref_log[ref_n] = ref_en_d;
                    ref_n++;
                    ref_en_q = ref_en_d;
                end
                if (low_tmr > 0) begin
                    low_tmr--;
                    if (low_tmr == 0) cnt_ready = 1'b0;
                end
                if (high_tmr > 0) begin
                    high_tmr--;
                    if (high_tmr == 0) begin
                        cnt_ready = 1'b1;
                        cnt_value = (run_idx == 1) ? short_v[24:0] : full_v[24:0];
                    end
                end
                if (cnt_wr) begin
                    if (wr_n < 8) begin
                        wr_ticks[wr_n] = cnt_ticks;
                        wr_st[wr_n]    = cnt_start;
                    end
                    wr_n++;
                    if (!cnt_start) low_tmr = low_dly;
                    else begin
                        if (cnt_ready) viol++;
                        run_idx++;
                        cnt_value = 25'h1555555;
                        high_tmr  = 3;
                    end
                end
            end
        end
    end

    task automatic clear_logs(input logic init_ref, input int unsigned s, input int unsigned f, input int ldly);
        ref_en_q = init_ref;
        short_v = s; full_v = f; low_dly = ldly;
        run_idx = 0; wr_n = 0; ref_n = 0; viol = 0; valid_n = 0;
    endtask

    task automatic pulse_req();
        @(negedge clk); req = 1'b1;
        @(negedge clk); req = 1'b0;
    endtask

    task automatic wait_valid(output bit seen);
        seen = 0;
        for (int i = 0; i < 3000; i++) begin
            if (rate_valid) begin seen = 1; break; end
            @(negedge clk);
        end
    endtask

    task automatic measure(input logic init_ref, input int unsigned s, input int unsigned f,
                           input int ldly, input string tag);
        bit seen;
        clear_logs(init_ref, s, f, ldly);
        pulse_req();
        wait_valid(seen);
        chk(seen, {tag, " valid seen"}, seen, 1);
        chk(rate == 32'(exp_rate(s, f)), tag, rate, exp_rate(s, f));
        chk(busy == 1'b1, "R9 busy during valid", busy, 1);
        @(negedge clk);
        chk(rate_valid == 1'b0, "R9 single pulse", rate_valid, 0);
        chk(busy == 1'b0, "R10 busy drops after result", busy, 0);
    endtask

    task automatic t_reset();
        chk(busy == 0 && rate_valid == 0 && cnt_wr == 0 && ref_en_wr == 0, "R1 strobes in reset",
            {busy, rate_valid, cnt_wr, ref_en_wr}, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(rate == 0, "R1 rate after reset", rate, 0);
        chk(busy == 0, "R1 busy after reset", busy, 0);
    endtask

    task automatic t_running();
        measure(1'b0, 1000, 16100, 2, "R8 running clock rate");
        chk(wr_n == 4, "R5 write count", wr_n, 4);
        chk(wr_ticks[0] == 20'h1000 && !wr_st[0], "R5 write0 short arm", wr_ticks[0], 20'h1000);
        chk(wr_ticks[1] == 20'h1000 && wr_st[1], "R5 write1 short start", wr_ticks[1], 20'h1000);
        chk(wr_ticks[2] == 20'h10000 && !wr_st[2], "R5 write2 full arm", wr_ticks[2], 20'h10000);
        chk(wr_ticks[3] == 20'h10000 && wr_st[3], "R5 write3 full start", wr_ticks[3], 20'h10000);
        chk(viol == 0, "R3 start only after ready low", viol, 0);
        chk(ref_n == 2 && ref_log[0] == 1'b1, "R2 branch enabled first", ref_log[0], 1);
        chk(ref_log[1] == 1'b0, "R6 branch restored low", ref_log[1], 0);
        repeat (5) @(negedge clk);
        chk(rate == 32'(exp_rate(1000, 16100)) && !rate_valid, "R9 rate held", rate, exp_rate(1000, 16100));
    endtask

    task automatic t_stopped();
        measure(1'b0, 777, 777, 2, "R7 equal counts give zero");
        measure(1'b0, 0, 0, 2, "R7 zero counts give zero");
    endtask

    task automatic t_ref_high();
        measure(1'b1, 2000, 40000, 2, "R8 rate with branch on");
        chk(ref_n == 2 && ref_log[0] == 1'b1 && ref_log[1] == 1'b1, "R6 branch restored high",
            ref_log[1], 1);
    endtask

    task automatic t_slow_ready();
        measure(1'b0, 4096, 65536, 9, "R4 capture only when ready");
        chk(viol == 0, "R3 slow ready drop respected", viol, 0);
        chk(wr_n == 4, "R3 four writes with slow ready", wr_n, 4);
    endtask

    task automatic t_edges();
        measure(1'b0, 100, 25'h1FFFFFF, 2, "R8 maximum count");
        measure(1'b0, 5000, 3000, 2, "R8 full below short");
    endtask

    task automatic t_ignore();
        bit seen;
        clear_logs(1'b0, 1234, 56789, 2);
        pulse_req();
        repeat (3) @(negedge clk);
        pulse_req();
        repeat (20) @(negedge clk);
        pulse_req();
        wait_valid(seen);
        chk(rate == 32'(exp_rate(1234, 56789)), "R10 result with extra requests", rate, exp_rate(1234, 56789));
        repeat (20) @(negedge clk);
        chk(valid_n == 1, "R10 one result only", valid_n, 1);
        chk(wr_n == 4, "R10 four writes only", wr_n, 4);
        chk(busy == 0, "R10 idle afterwards", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_running();
        t_stopped();
        t_ref_high();
        t_slow_ready();
        t_edges();
        t_ignore();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule